// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block is the arithmetic and logic core of a small accumulator machine. It holds a 32-bit accumulator, a one-bit carry flag, two scratch registers (X and Y), a high/low register pair for the wide integer product and an output port register. A controller presents one encoded operation together with a strobe. On the clock edge where the strobe is sampled high, exactly that one operation takes effect. Operands come from the general-purpose register input, the input port, the scratch registers, the product pair and the accumulator itself.

Every candidate accumulator value is formed at the same time in a bank of parallel units. A selector then picks the one named by the decoded operation. The floating-point add, subtract and multiply units sit outside this block. Their results enter through three input ports and are chosen like any other candidate. The scratch registers are filled by copying the accumulator into them, and the output port register is loaded from the accumulator on command.

Top module: `accum_alu`

## Requirements
- R1: An active-low asynchronous reset clears the accumulator, the flag, X, Y, Hi, Lo and the output port register to zero.
- R2: With the strobe low, no register changes. With the strobe high, the operation takes effect on that clock edge and is visible after it.
- R3: Code 5 sets acc = acc + gpr and code 12 sets acc = acc + 1. Both write the carry-out of the 32-bit sum into the flag.
- R4: Code 18 sets acc = acc - gpr modulo 2^32 and code 4 sets acc = acc - 1. Neither changes the flag.
- R5: Code 10 shifts the accumulator toward the MSB, puts 0 in bit 0 and puts the old bit 31 into the flag. Code 11 shifts toward the LSB, puts 0 in bit 31 and puts the old bit 0 into the flag.
- R6: Code 7 rotates right (old bit 0 goes to bit 31) and code 8 rotates left (old bit 31 goes to bit 0). Neither rotate changes the flag.
- R7: Code 19 writes the 64-bit unsigned product acc*gpr into Hi (upper half) and Lo (lower half), leaving acc and the flag unchanged. Code 20 copies Hi into acc and code 21 copies Lo into acc.
- R8: Code 15 loads X AND Y, 16 loads X OR Y, 13 loads X, 14 loads Y, 6 loads gpr, 17 loads the input port and 9 loads the bitwise complement of acc. None of these changes the flag.
- R9: Code 28 copies acc into X and code 29 copies acc into Y.
- R10: Codes 22, 23 and 24 load the floating-point add, subtract and multiply result inputs into acc.
- R11: Code 26 copies acc into the output port register. The output port register holds its value under every other code except the general reset.
- R12: Codes 0, 1, 2, 3, 25 and 27 zero X, Y, Hi, Lo, acc and the flag respectively, and touch nothing else. Code 30 zeros all of these and the output port register.
- R13: Code 31 is undefined and leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Encoded operation |
| gpr_i | input | 32 | General-purpose register operand |
| port_i | input | 32 | Input port value |
| fadd_i | input | 32 | Floating-point sum result |
| fsub_i | input | 32 | Floating-point difference result |
| fmul_i | input | 32 | Floating-point product result |
| acc_o | output | 32 | Accumulator |
| flag_o | output | 1 | Carry flag |
| port_o | output | 32 | Output port register |

## Verification
Every result in this block is registered once. An operation strobed at a rising edge shows its effect on the accumulator, the flag, the output port or the hidden registers immediately after that same edge, and there is no further pipeline delay. The bench drives each strobe and its operands at a falling edge and holds them for one full period. It samples the outputs at the following falling edge, half a cycle after the update and before any new stimulus. X, Y, Hi and Lo have no ports of their own, so they are read back one operation later through a load-to-accumulator code.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OP_CLR_X   = 5'd0;
  localparam logic [OPC_W-1:0] OP_CLR_Y   = 5'd1;
  localparam logic [OPC_W-1:0] OP_CLR_HI  = 5'd2;
  localparam logic [OPC_W-1:0] OP_CLR_LO  = 5'd3;
  localparam logic [OPC_W-1:0] OP_DEC     = 5'd4;
  localparam logic [OPC_W-1:0] OP_ADD     = 5'd5;
  localparam logic [OPC_W-1:0] OP_LD_GPR  = 5'd6;
  localparam logic [OPC_W-1:0] OP_ROR     = 5'd7;
  localparam logic [OPC_W-1:0] OP_ROL     = 5'd8;
  localparam logic [OPC_W-1:0] OP_CPL     = 5'd9;
  localparam logic [OPC_W-1:0] OP_SHL     = 5'd10;
  localparam logic [OPC_W-1:0] OP_SHR     = 5'd11;
  localparam logic [OPC_W-1:0] OP_INC     = 5'd12;
  localparam logic [OPC_W-1:0] OP_LD_X    = 5'd13;
  localparam logic [OPC_W-1:0] OP_LD_Y    = 5'd14;
  localparam logic [OPC_W-1:0] OP_AND_XY  = 5'd15;
  localparam logic [OPC_W-1:0] OP_OR_XY   = 5'd16;
  localparam logic [OPC_W-1:0] OP_LD_PIN  = 5'd17;
  localparam logic [OPC_W-1:0] OP_SUB     = 5'd18;
  localparam logic [OPC_W-1:0] OP_MUL     = 5'd19;
  localparam logic [OPC_W-1:0] OP_LD_HI   = 5'd20;
  localparam logic [OPC_W-1:0] OP_LD_LO   = 5'd21;
  localparam logic [OPC_W-1:0] OP_LD_FADD = 5'd22;
  localparam logic [OPC_W-1:0] OP_LD_FSUB = 5'd23;
  localparam logic [OPC_W-1:0] OP_LD_FMUL = 5'd24;
  localparam logic [OPC_W-1:0] OP_CLR_ACC = 5'd25;
  localparam logic [OPC_W-1:0] OP_OUT     = 5'd26;
  localparam logic [OPC_W-1:0] OP_CLR_F   = 5'd27;
  localparam logic [OPC_W-1:0] OP_ST_X    = 5'd28;
  localparam logic [OPC_W-1:0] OP_ST_Y    = 5'd29;
  localparam logic [OPC_W-1:0] OP_RST_ALL = 5'd30;

  // candidate accumulator sources, one per parallel unit
  typedef enum logic [4:0] {
    SRC_ZERO, SRC_DEC, SRC_ADD, SRC_GPR, SRC_ROR, SRC_ROL, SRC_CPL,
    SRC_SHL, SRC_SHR, SRC_INC, SRC_X, SRC_Y, SRC_AND, SRC_OR, SRC_PIN,
    SRC_SUB, SRC_HI, SRC_LO, SRC_FADD, SRC_FSUB, SRC_FMUL
  } src_e;

  localparam int NSRC  = 21;
  localparam int SRC_W = $clog2(NSRC);

  typedef enum logic [2:0] {
    FL_KEEP, FL_ZERO, FL_ADD, FL_INC, FL_MSB, FL_LSB
  } flsrc_e;

  typedef enum logic [1:0] {
    RG_KEEP, RG_CLR, RG_LOAD
  } rgop_e;

  typedef struct packed {
    logic   acc_we;
    src_e   acc_src;
    flsrc_e f_src;
    rgop_e  x_op;
    rgop_e  y_op;
    rgop_e  hi_op;
    rgop_e  lo_op;
    logic   pout_we;
    logic   clr_all;
  } ctrl_t;

endpackage

// File: rtl/accalu_decode.sv
module accalu_decode
  import accalu_pkg::*;
(
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl.acc_we  = 1'b0;
    ctrl.acc_src = SRC_ZERO;
    ctrl.f_src   = FL_KEEP;
    ctrl.x_op    = RG_KEEP;
    ctrl.y_op    = RG_KEEP;
    ctrl.hi_op   = RG_KEEP;
    ctrl.lo_op   = RG_KEEP;
    ctrl.pout_we = 1'b0;
    ctrl.clr_all = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_CLR_X:   ctrl.x_op  = RG_CLR;
        OP_CLR_Y:   ctrl.y_op  = RG_CLR;
        OP_CLR_HI:  ctrl.hi_op = RG_CLR;
        OP_CLR_LO:  ctrl.lo_op = RG_CLR;
        OP_DEC:     begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_DEC; end
        OP_ADD:     begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_ADD;
                          ctrl.f_src = FL_ADD; end
        OP_LD_GPR:  begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_GPR; end
        OP_ROR:     begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_ROR; end
        OP_ROL:     begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_ROL; end
        OP_CPL:     begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_CPL; end
        OP_SHL:     begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_SHL;
                          ctrl.f_src = FL_MSB; end
        OP_SHR:     begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_SHR;
                          ctrl.f_src = FL_LSB; end
        OP_INC:     begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_INC;
                          ctrl.f_src = FL_INC; end
        OP_LD_X:    begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_X; end
        OP_LD_Y:    begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_Y; end
        OP_AND_XY:  begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_AND; end
        OP_OR_XY:   begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_OR; end
        OP_LD_PIN:  begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_PIN; end
        OP_SUB:     begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_SUB; end
        OP_MUL:     begin ctrl.hi_op = RG_LOAD; ctrl.lo_op = RG_LOAD; end
        OP_LD_HI:   begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_HI; end
        OP_LD_LO:   begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_LO; end
        OP_LD_FADD: begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_FADD; end
        OP_LD_FSUB: begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_FSUB; end
        OP_LD_FMUL: begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_FMUL; end
        OP_CLR_ACC: begin ctrl.acc_we = 1'b1; ctrl.acc_src = SRC_ZERO; end
        OP_OUT:     ctrl.pout_we = 1'b1;
        OP_CLR_F:   ctrl.f_src = FL_ZERO;
        OP_ST_X:    ctrl.x_op = RG_LOAD;
        OP_ST_Y:    ctrl.y_op = RG_LOAD;
        OP_RST_ALL: ctrl.clr_all = 1'b1;
        default:    ctrl.clr_all = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/accalu_cands.sv
module accalu_cands
  import accalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                     [W-1:0] acc,
  input  logic                     [W-1:0] gpr,
  input  logic                     [W-1:0] pin,
  input  logic                     [W-1:0] x,
  input  logic                     [W-1:0] y,
  input  logic                     [W-1:0] hi,
  input  logic                     [W-1:0] lo,
  input  logic                     [W-1:0] fadd,
  input  logic                     [W-1:0] fsub,
  input  logic                     [W-1:0] fmul,
  output logic [NSRC-1:0]          [W-1:0] cand,
  output logic                             add_c,
  output logic                             inc_c
);

  logic [W:0] add_w;
  logic [W:0] inc_w;

  always_comb begin
    add_w = {1'b0, acc} + {1'b0, gpr};
    inc_w = {1'b0, acc} + {{W{1'b0}}, 1'b1};
    add_c = add_w[W];
    inc_c = inc_w[W];
  end

  always_comb begin
    cand           = '0;
    cand[SRC_ZERO] = '0;
    cand[SRC_DEC]  = acc - {{(W-1){1'b0}}, 1'b1};
    cand[SRC_ADD]  = add_w[W-1:0];
    cand[SRC_GPR]  = gpr;
    cand[SRC_ROR]  = {acc[0], acc[W-1:1]};
    cand[SRC_ROL]  = {acc[W-2:0], acc[W-1]};
    cand[SRC_CPL]  = ~acc;
    cand[SRC_SHL]  = {acc[W-2:0], 1'b0};
    cand[SRC_SHR]  = {1'b0, acc[W-1:1]};
    cand[SRC_INC]  = inc_w[W-1:0];
    cand[SRC_X]    = x;
    cand[SRC_Y]    = y;
    cand[SRC_AND]  = x & y;
    cand[SRC_OR]   = x | y;
    cand[SRC_PIN]  = pin;
    cand[SRC_SUB]  = acc - gpr;
    cand[SRC_HI]   = hi;
    cand[SRC_LO]   = lo;
    cand[SRC_FADD] = fadd;
    cand[SRC_FSUB] = fsub;
    cand[SRC_FMUL] = fmul;
  end

endmodule

// File: rtl/accalu_select.sv
module accalu_select #(
  parameter int W     = 32,
  parameter int N     = 21,
  parameter int SEL_W = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] cand,
  input  logic [SEL_W-1:0]    sel,
  output logic [W-1:0]        y
);

  logic [N-1:0][W-1:0] masked;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign masked[i] = (sel == SEL_W'(i)) ? cand[i] : '0;
  end

  always_comb begin
    y = '0;
    for (int i = 0; i < N; i++) begin
      y = y | masked[i];
    end
  end

endmodule

// File: rtl/accalu_mul.sv
module accalu_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);

  always_comb begin
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [DATA_W-1:0] gpr_i,
  input  logic [DATA_W-1:0] port_i,
  input  logic [DATA_W-1:0] fadd_i,
  input  logic [DATA_W-1:0] fsub_i,
  input  logic [DATA_W-1:0] fmul_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] port_o
);

  localparam int PROD_W = 2 * DATA_W;

  ctrl_t ctrl;

  logic [DATA_W-1:0] acc_q, acc_d;
  logic              f_q, f_d;
  logic [DATA_W-1:0] x_q, x_d;
  logic [DATA_W-1:0] y_q, y_d;
  logic [DATA_W-1:0] hi_q, hi_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  logic [DATA_W-1:0] pout_q, pout_d;

  logic [NSRC-1:0][DATA_W-1:0] cand;
  logic                        add_c, inc_c;
  logic [DATA_W-1:0]           acc_sel;
  logic [PROD_W-1:0]           prod;
  logic                        upd_en;

  accalu_decode u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .ctrl     (ctrl)
  );

  accalu_cands #(.W(DATA_W)) u_cands (
    .acc   (acc_q),
    .gpr   (gpr_i),
    .pin   (port_i),
    .x     (x_q),
    .y     (y_q),
    .hi    (hi_q),
    .lo    (lo_q),
    .fadd  (fadd_i),
    .fsub  (fsub_i),
    .fmul  (fmul_i),
    .cand  (cand),
    .add_c (add_c),
    .inc_c (inc_c)
  );

  accalu_select #(.W(DATA_W), .N(NSRC), .SEL_W(SRC_W)) u_sel (
    .cand (cand),
    .sel  (ctrl.acc_src),
    .y    (acc_sel)
  );

  accalu_mul #(.W(DATA_W)) u_mul (
    .a (acc_q),
    .b (gpr_i),
    .p (prod)
  );

  assign upd_en = op_valid;

  // next-state
  always_comb begin
    acc_d  = acc_q;
    f_d    = f_q;
    x_d    = x_q;
    y_d    = y_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    pout_d = pout_q;
    if (ctrl.clr_all) begin
      acc_d  = '0;
      f_d    = 1'b0;
      x_d    = '0;
      y_d    = '0;
      hi_d   = '0;
      lo_d   = '0;
      pout_d = '0;
    end else begin
      if (ctrl.acc_we) acc_d = acc_sel;
      case (ctrl.f_src)
        FL_ZERO: f_d = 1'b0;
        FL_ADD:  f_d = add_c;
        FL_INC:  f_d = inc_c;
        FL_MSB:  f_d = acc_q[DATA_W-1];
        FL_LSB:  f_d = acc_q[0];
        default: f_d = f_q;
      endcase
      case (ctrl.x_op)
        RG_CLR:  x_d = '0;
        RG_LOAD: x_d = acc_q;
        default: x_d = x_q;
      endcase
      case (ctrl.y_op)
        RG_CLR:  y_d = '0;
        RG_LOAD: y_d = acc_q;
        default: y_d = y_q;
      endcase
      case (ctrl.hi_op)
        RG_CLR:  hi_d = '0;
        RG_LOAD: hi_d = prod[PROD_W-1:DATA_W];
        default: hi_d = hi_q;
      endcase
      case (ctrl.lo_op)
        RG_CLR:  lo_d = '0;
        RG_LOAD: lo_d = prod[DATA_W-1:0];
        default: lo_d = lo_q;
      endcase
      if (ctrl.pout_we) pout_d = acc_q;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      f_q    <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      pout_q <= '0;
    end else if (upd_en) begin
      acc_q  <= acc_d;
      f_q    <= f_d;
      x_q    <= x_d;
      y_q    <= y_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      pout_q <= pout_d;
    end
  end

  assign acc_o  = acc_q;
  assign flag_o = f_q;
  assign port_o = pout_q;

endmodule

// File: rtl/accalu_chk.sv
module accalu_chk
  import accalu_pkg::*;
#(
  parameter int W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OPC_W-1:0] op_code,
  input logic [W-1:0]     gpr_i,
  input logic [W-1:0]     acc_o,
  input logic             flag_o,
  input logic [W-1:0]     port_o
);

  logic strobe_add, strobe_sub, strobe_shl, strobe_ror, strobe_out, strobe_bad;

  always_comb begin
    strobe_add = op_valid && (op_code == OP_ADD);
    strobe_sub = op_valid && (op_code == OP_SUB);
    strobe_shl = op_valid && (op_code == OP_SHL);
    strobe_ror = op_valid && (op_code == OP_ROR);
    strobe_out = op_valid && (op_code == OP_OUT);
    strobe_bad = op_valid && (op_code == 5'd31);
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_o) && $stable(flag_o) && $stable(port_o)));

  p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_add |=> ({flag_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(gpr_i)})));

  p_sub_keeps_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_sub |=> ($stable(flag_o) && (acc_o == $past(acc_o) - $past(gpr_i))));

  p_shl_msb_to_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_shl |=> ((flag_o == $past(acc_o[W-1])) && (acc_o[0] == 1'b0)));

  p_ror_circular_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ror |=> ($stable(flag_o) && (acc_o == {$past(acc_o[0]), $past(acc_o[W-1:1])})));

  p_out_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_out |=> ((port_o == $past(acc_o)) && $stable(acc_o)));

  p_undef_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_bad |=> ($stable(acc_o) && $stable(flag_o) && $stable(port_o)));

endmodule

bind accum_alu accalu_chk #(.W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .gpr_i    (gpr_i),
  .acc_o    (acc_o),
  .flag_o   (flag_o),
  .port_o   (port_o)
);

// File: tb/accum_alu_tb.sv
`timescale 1ns/1ps
module accum_alu_tb;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  op_code;
  logic [31:0] gpr_i, port_i, fadd_i, fsub_i, fmul_i;
  logic [31:0] acc_o, port_o;
  logic        flag_o;

  int n_total = 0;
  int n_bad   = 0;

  accum_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .gpr_i(gpr_i), .port_i(port_i), .fadd_i(fadd_i), .fsub_i(fsub_i),
    .fmul_i(fmul_i), .acc_o(acc_o), .flag_o(flag_o), .port_o(port_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk32(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_total++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic chk1(input string req, input logic got, input logic exp);
    n_total++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  // strobe one code; returns at the falling edge after the update
  task automatic do_op(input logic [4:0] c);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = c;
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = 5'd31;
  endtask

  task automatic set_acc(input logic [31:0] v);
    gpr_i = v;
    do_op(5'd6);
  endtask

  task automatic t_reset;
    chk32("R1 acc after reset", acc_o, 32'h0);
    chk1 ("R1 flag after reset", flag_o, 1'b0);
    chk32("R1 port after reset", port_o, 32'h0);
    set_acc(32'h1234_5678);
    do_op(5'd28);
    do_op(5'd26);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk32("R1 acc cleared mid-run", acc_o, 32'h0);
    chk32("R1 port cleared mid-run", port_o, 32'h0);
    rst_n = 1'b1;
    set_acc(32'h5);
    do_op(5'd13);
    chk32("R1 X cleared by reset", acc_o, 32'h0);
  endtask

  task automatic t_add_inc;
    do_op(5'd27);
    set_acc(32'h5);
    gpr_i = 32'h7;
    do_op(5'd5);
    chk32("R3 add 5+7", acc_o, 32'hC);
    chk1 ("R3 add no carry", flag_o, 1'b0);
    set_acc(32'hFFFF_FFFF);
    gpr_i = 32'h1;
    do_op(5'd5);
    chk32("R3 add wrap", acc_o, 32'h0);
    chk1 ("R3 add carry", flag_o, 1'b1);
    set_acc(32'hFFFF_FFFF);
    do_op(5'd27);
    do_op(5'd12);
    chk32("R3 inc wrap", acc_o, 32'h0);
    chk1 ("R3 inc carry", flag_o, 1'b1);
    do_op(5'd12);
    chk32("R3 inc 0", acc_o, 32'h1);
    chk1 ("R3 inc no carry", flag_o, 1'b0);
  endtask

  task automatic t_dec_sub;
    set_acc(32'hFFFF_FFFF);
    do_op(5'd12);
    set_acc(32'h3);
    chk1("R8 load keeps flag", flag_o, 1'b1);
    gpr_i = 32'h5;
    do_op(5'd18);
    chk32("R4 sub 3-5", acc_o, 32'hFFFF_FFFE);
    chk1 ("R4 sub keeps flag 1", flag_o, 1'b1);
    do_op(5'd4);
    chk32("R4 dec", acc_o, 32'hFFFF_FFFD);
    chk1 ("R4 dec keeps flag 1", flag_o, 1'b1);
    do_op(5'd27);
    chk1 ("R12 clear flag", flag_o, 1'b0);
    chk32("R12 clear flag leaves acc", acc_o, 32'hFFFF_FFFD);
    set_acc(32'h0);
    do_op(5'd4);
    chk32("R4 dec from 0", acc_o, 32'hFFFF_FFFF);
    chk1 ("R4 dec keeps flag 0", flag_o, 1'b0);
  endtask

  task automatic t_shift;
    set_acc(32'h8000_0001);
    do_op(5'd10);
    chk32("R5 shl value", acc_o, 32'h0000_0002);
    chk1 ("R5 shl flag=msb", flag_o, 1'b1);
    set_acc(32'h8000_0001);
    do_op(5'd11);
    chk32("R5 shr value", acc_o, 32'h4000_0000);
    chk1 ("R5 shr flag=lsb", flag_o, 1'b1);
    do_op(5'd11);
    chk32("R5 shr again", acc_o, 32'h2000_0000);
    chk1 ("R5 shr flag 0", flag_o, 1'b0);
  endtask

  task automatic t_rotate;
    set_acc(32'h8000_0001);
    do_op(5'd7);
    chk32("R6 ror", acc_o, 32'hC000_0000);
    chk1 ("R6 ror flag kept", flag_o, 1'b0);
    set_acc(32'h8000_0001);
    do_op(5'd8);
    chk32("R6 rol", acc_o, 32'h0000_0003);
    set_acc(32'hFFFF_FFFF);
    do_op(5'd12);
    set_acc(32'h0000_0002);
    do_op(5'd7);
    chk32("R6 ror no wrap", acc_o, 32'h0000_0001);
    chk1 ("R6 ror flag kept 1", flag_o, 1'b1);
  endtask

  task automatic t_mul;
    set_acc(32'hFFFF_FFFF);
    do_op(5'd19);
    chk32("R7 mul leaves acc", acc_o, 32'hFFFF_FFFF);
    do_op(5'd20);
    chk32("R7 hi", acc_o, 32'hFFFF_FFFE);
    do_op(5'd21);
    chk32("R7 lo", acc_o, 32'h0000_0001);
    set_acc(32'h0001_0003);
    do_op(5'd19);
    do_op(5'd21);
    chk32("R7 lo small", acc_o, 32'h0006_0009);
    do_op(5'd20);
    chk32("R7 hi small", acc_o, 32'h0000_0001);
  endtask

  task automatic t_logic;
    set_acc(32'hF0F0_00FF);
    do_op(5'd28);
    set_acc(32'h0FF0_0F0F);
    do_op(5'd29);
    do_op(5'd15);
    chk32("R8 and xy", acc_o, 32'h00F0_000F);
    do_op(5'd16);
    chk32("R8 or xy", acc_o, 32'hFFF0_0FFF);
    do_op(5'd13);
    chk32("R9 store/load X", acc_o, 32'hF0F0_00FF);
    do_op(5'd14);
    chk32("R9 store/load Y", acc_o, 32'h0FF0_0F0F);
    do_op(5'd9);
    chk32("R8 complement", acc_o, 32'hF00F_F0F0);
    port_i = 32'hA5A5_5A5A;
    do_op(5'd17);
    chk32("R8 load port", acc_o, 32'hA5A5_5A5A);
  endtask

  task automatic t_fp;
    fadd_i = 32'h1111_1111;
    fsub_i = 32'h2222_2222;
    fmul_i = 32'h3333_3333;
    do_op(5'd22);
    chk32("R10 fadd", acc_o, 32'h1111_1111);
    do_op(5'd23);
    chk32("R10 fsub", acc_o, 32'h2222_2222);
    do_op(5'd24);
    chk32("R10 fmul", acc_o, 32'h3333_3333);
  endtask

  task automatic t_out;
    set_acc(32'hDEAD_BEEF);
    do_op(5'd26);
    chk32("R11 port copy", port_o, 32'hDEAD_BEEF);
    set_acc(32'h1234_5678);
    do_op(5'd9);
    chk32("R11 port holds", port_o, 32'hDEAD_BEEF);
  endtask

  task automatic t_clear;
    set_acc(32'hAAAA_5555);
    do_op(5'd28);
    do_op(5'd29);
    do_op(5'd0);
    do_op(5'd14);
    chk32("R12 clr X leaves Y", acc_o, 32'hAAAA_5555);
    do_op(5'd13);
    chk32("R12 clr X", acc_o, 32'h0);
    do_op(5'd1);
    set_acc(32'h7);
    do_op(5'd14);
    chk32("R12 clr Y", acc_o, 32'h0);
    set_acc(32'h0001_0003);
    do_op(5'd19);
    do_op(5'd2);
    do_op(5'd20);
    chk32("R12 clr Hi", acc_o, 32'h0);
    do_op(5'd21);
    chk32("R12 clr Hi leaves Lo", acc_o, 32'h0006_0009);
    do_op(5'd3);
    do_op(5'd21);
    chk32("R12 clr Lo", acc_o, 32'h0);
    set_acc(32'h55);
    do_op(5'd25);
    chk32("R12 clr acc", acc_o, 32'h0);
    set_acc(32'hFFFF_FFFF);
    do_op(5'd12);
    set_acc(32'h77);
    do_op(5'd28);
    do_op(5'd26);
    do_op(5'd30);
    chk32("R12 reset-all acc", acc_o, 32'h0);
    chk1 ("R12 reset-all flag", flag_o, 1'b0);
    chk32("R12 reset-all port", port_o, 32'h0);
    set_acc(32'h9);
    do_op(5'd13);
    chk32("R12 reset-all X", acc_o, 32'h0);
  endtask

  task automatic t_undef_idle;
    set_acc(32'hFFFF_FFFF);
    do_op(5'd12);
    set_acc(32'hCAFE_F00D);
    do_op(5'd26);
    do_op(5'd31);
    chk32("R13 undef acc", acc_o, 32'hCAFE_F00D);
    chk1 ("R13 undef flag", flag_o, 1'b1);
    chk32("R13 undef port", port_o, 32'hCAFE_F00D);
    do_op(5'd13);
    chk32("R13 undef X kept", acc_o, 32'h0);
    set_acc(32'h10);
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = 5'd5;
    gpr_i    = 32'h1;
    repeat (3) @(negedge clk);
    chk32("R2 idle acc", acc_o, 32'h10);
    chk1 ("R2 idle flag", flag_o, 1'b1);
    op_code = 5'd31;
  endtask

  initial begin
    #800000;
    n_total++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_code  = 5'd31;
    gpr_i    = '0;
    port_i   = '0;
    fadd_i   = '0;
    fsub_i   = '0;
    fmul_i   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_add_inc;
    t_dec_sub;
    t_shift;
    t_rotate;
    t_mul;
    t_logic;
    t_fp;
    t_out;
    t_clear;
    t_undef_idle;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule